// File: doc/BRIEF.md
# MII Transmit Framer

The block turns a byte stream into a complete Ethernet frame on a 4-bit MII transmit bus running from a 25 MHz nibble clock at 100 Mb/s. The upstream source supplies the header bytes (destination address, source address, type/length) and the payload as one byte stream. The framer puts the preamble and start-of-frame delimiter in front of them. It pads short frames with zero bytes and appends a 32-bit frame check sequence. It then holds the line idle for the minimum inter-packet gap before it starts the next frame. The transmit enable stays high without a break from the first preamble nibble to the last check-sequence nibble. The transmit error line is never raised.

Each byte takes two clocks on the wire, low nibble first. The input handshake uses valid, ready and last. Ready is raised for one clock in each byte slot of the payload phase, and a byte moves on a clock edge where valid and ready are both high. The source is expected to keep bytes flowing. If valid is low in a slot where ready is high, the payload closes at that point, and the frame is padded and finished with transmit enable still held high.

The controller walks through seven states:
- IDLE: waits for valid; IDLE to PRE on valid.
- PRE: sends seven preamble bytes; PRE to SFD after the seventh.
- SFD: sends the delimiter and takes the first byte. SFD to DATA when a byte is taken. SFD to PAD when valid is low.
- DATA: carries the stream. It stays in DATA while bytes come. DATA to PAD at the end of the stream if the frame is short, and DATA to FCS if it is long enough.
- PAD: sends filler; PAD to FCS once 60 bytes have gone out.
- FCS: sends the four check bytes; FCS to GAP after the fourth.
- GAP: counts 24 idle clocks. GAP to PRE if valid is waiting, otherwise GAP to IDLE.

Top module: `mii_tx_framer`

## Requirements
- R1: Every frame opens with seven 0x55 bytes and then the delimiter 0xD5. Each byte goes out low nibble first, so the first nibble after transmit enable rises is 0x5, and the delimiter shows as 0x5 followed by 0xD.
- R2: After the delimiter, the accepted input bytes follow unchanged and in order, one byte per two clocks.
- R3: When fewer than 60 bytes have been accepted, 0x00 bytes are sent after the last accepted byte until 60 bytes have gone out after the delimiter.
- R4: The last four bytes carry a CRC-32 over the accepted bytes and the pad bytes, least significant byte first. The CRC uses the reflected polynomial 0x04C11DB7, starts from 0xFFFFFFFF and is inverted at the end.
- R5: Transmit enable is high on every clock from the first preamble nibble to the last check-sequence nibble. A frame therefore lasts an even number of clocks and at least 144 clocks.
- R6: Transmit enable stays low for at least 24 clocks between frames. When the next frame's first byte is already valid during the gap, the low time is exactly 24 clocks.
- R7: The transmit error output is always 0, and the data nibble is 0 whenever transmit enable is low.
- R8: Ready is high only while transmit enable is high, and only in byte slots where the framer takes a stream byte. It is never high during the preamble, the padding, the check sequence, the gap or idle.
- R9: If valid is low in a slot where ready is high, the payload ends there. The frame is closed with padding and the check sequence, with no break in transmit enable.
- R10: After reset, transmit enable, the data nibble and ready are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz transmit nibble clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Stream byte (header and payload) |
| in_valid | input | 1 | Stream byte valid |
| in_last | input | 1 | Marks the final stream byte of a frame |
| in_ready | output | 1 | Framer takes the byte on this clock edge |
| mii_txd | output | 4 | Transmit data nibble |
| mii_tx_en | output | 1 | Transmit enable |
| mii_tx_er | output | 1 | Transmit error, held low |

## Verification
The bench goes after frames whose lengths sit just below, at and just above the 60-byte minimum. A pad counter that is off by one shows up there as a frame one byte short or long, with a wrong check sequence. Back-to-back frames with the next byte already waiting measure the gap, to catch a framer that shortens it or restarts without it. A stream that stops without a last marker checks that the frame closes with padding and does not drop transmit enable in mid-frame. A one-byte frame checks that the delimiter slot can both take and close the payload. Random lengths and contents check the nibble order and the check-sequence byte order, because a swapped nibble or a reversed CRC byte corrupts every such frame.

// File: rtl/mii_txf_pkg.sv
package mii_txf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SFD,
        ST_DATA,
        ST_PAD,
        ST_FCS,
        ST_GAP
    } txf_state_e;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED      = 32'hFFFFFFFF;
    localparam logic [7:0]  PRE_BYTE      = 8'h55;
    localparam logic [7:0]  SFD_BYTE      = 8'hD5;

    // One byte of the reflected CRC-32, least significant bit first.
    function automatic logic [31:0] crc32_byte(input logic [31:0] c_in, input logic [7:0] d);
        logic [31:0] c;
        logic        fb;
        c = c_in;
        for (int i = 0; i < 8; i++) begin
            fb = c[0] ^ d[i];
            c  = {1'b0, c[31:1]} ^ (fb ? CRC_POLY_REFL : 32'h0);
        end
        return c;
    endfunction

endpackage

// File: rtl/mii_txf_crc.sv
module mii_txf_crc
    import mii_txf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] crc
);
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            crc <= CRC_SEED;
        end else if (en) begin
            crc <= crc32_byte(crc, din);
        end
    end
endmodule

// File: rtl/mii_txf_gap.sv
module mii_txf_gap #(
    parameter int GAP_CLKS = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = (GAP_CLKS > 1) ? $clog2(GAP_CLKS) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = run && (cnt_q == CW'(GAP_CLKS - 1));
endmodule

// File: rtl/mii_tx_framer.sv
module mii_tx_framer
    import mii_txf_pkg::*;
#(
    parameter int PRE_BYTES = 7,
    parameter int MIN_FRAME = 60,
    parameter int GAP_CLKS  = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    input  logic       in_last,
    output logic       in_ready,
    output logic [3:0] mii_txd,
    output logic       mii_tx_en,
    output logic       mii_tx_er
);
    localparam int FCS_BYTES = 4;
    localparam int CNT_MAX   = (PRE_BYTES > FCS_BYTES) ? PRE_BYTES : FCS_BYTES;
    localparam int CNT_W     = $clog2(CNT_MAX);
    localparam int LEN_W     = $clog2(MIN_FRAME + 1);

    txf_state_e       st_q, st_n;
    logic             phase_q, phase_n;
    logic [7:0]       byte_q, byte_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [LEN_W-1:0] len_q, len_n;
    logic             last_q, last_n;

    logic             crc_init, crc_en;
    logic [7:0]       crc_din;
    logic [31:0]      crc_q;
    logic [31:0]      fcs_val;
    logic [1:0]       fcs_idx;
    logic             gap_done;
    logic             on_wire;
    logic             slot_end;

    mii_txf_crc u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (crc_init),
        .en    (crc_en),
        .din   (crc_din),
        .crc   (crc_q)
    );

    mii_txf_gap #(.GAP_CLKS(GAP_CLKS)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st_q == ST_GAP),
        .done  (gap_done)
    );

    assign on_wire  = (st_q != ST_IDLE) && (st_q != ST_GAP);
    assign slot_end = on_wire && phase_q;
    assign fcs_val  = ~crc_q;
    assign fcs_idx  = 2'(cnt_q) + 2'd1;

    // Next-state logic.
    always_comb begin
        st_n     = st_q;
        phase_n  = on_wire ? ~phase_q : 1'b0;
        byte_n   = byte_q;
        cnt_n    = cnt_q;
        len_n    = len_q;
        last_n   = last_q;
        crc_init = 1'b0;
        crc_en   = 1'b0;
        crc_din  = 8'h00;
        unique case (st_q)
            ST_IDLE, ST_GAP: begin
                if (st_q == ST_IDLE || gap_done) begin
                    if (in_valid) begin
                        st_n     = ST_PRE;
                        phase_n  = 1'b0;
                        byte_n   = PRE_BYTE;
                        cnt_n    = '0;
                        len_n    = '0;
                        last_n   = 1'b0;
                        crc_init = 1'b1;
                    end else begin
                        st_n = ST_IDLE;
                    end
                end
            end
            ST_PRE: begin
                if (slot_end) begin
                    if (cnt_q == CNT_W'(PRE_BYTES - 1)) begin
                        st_n   = ST_SFD;
                        byte_n = SFD_BYTE;
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
            end
            ST_SFD, ST_DATA, ST_PAD: begin
                if (slot_end) begin
                    if (st_q != ST_PAD && !last_q && in_valid) begin
                        st_n    = ST_DATA;
                        byte_n  = in_data;
                        last_n  = in_last;
                        crc_en  = 1'b1;
                        crc_din = in_data;
                        if (len_q < LEN_W'(MIN_FRAME)) len_n = len_q + 1'b1;
                    end else if (len_q < LEN_W'(MIN_FRAME)) begin
                        st_n    = ST_PAD;
                        byte_n  = 8'h00;
                        crc_en  = 1'b1;
                        crc_din = 8'h00;
                        len_n   = len_q + 1'b1;
                    end else begin
                        st_n   = ST_FCS;
                        byte_n = fcs_val[7:0];
                        cnt_n  = '0;
                    end
                end
            end
            ST_FCS: begin
                if (slot_end) begin
                    if (cnt_q == CNT_W'(FCS_BYTES - 1)) begin
                        st_n   = ST_GAP;
                        byte_n = 8'h00;
                    end else begin
                        cnt_n  = cnt_q + 1'b1;
                        byte_n = fcs_val[{fcs_idx, 3'b000} +: 8];
                    end
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            phase_q <= 1'b0;
            byte_q  <= 8'h00;
            cnt_q   <= '0;
            len_q   <= '0;
            last_q  <= 1'b0;
        end else begin
            st_q    <= st_n;
            phase_q <= phase_n;
            byte_q  <= byte_n;
            cnt_q   <= cnt_n;
            len_q   <= len_n;
            last_q  <= last_n;
        end
    end

    // Outputs.
    always_comb begin
        mii_tx_en = on_wire;
        mii_tx_er = 1'b0;
        mii_txd   = on_wire ? (phase_q ? byte_q[7:4] : byte_q[3:0]) : 4'h0;
        in_ready  = slot_end && !last_q &&
                    ((st_q == ST_SFD) || (st_q == ST_DATA));
    end
endmodule

// File: rtl/mii_tx_framer_chk.sv
module mii_tx_framer_chk #(
    parameter int PRE_BYTES = 7,
    parameter int MIN_FRAME = 60,
    parameter int GAP_CLKS  = 24
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_ready,
    input logic [3:0] mii_txd,
    input logic       mii_tx_en,
    input logic       mii_tx_er
);
    localparam int MIN_HI = 2 * (PRE_BYTES + 1 + MIN_FRAME + 4);
    localparam int LW     = $clog2(GAP_CLKS + 1);

    logic [LW-1:0] low_cnt;
    logic [15:0]   hi_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= LW'(GAP_CLKS);
            hi_cnt  <= '0;
        end else begin
            if (mii_tx_en)                     low_cnt <= '0;
            else if (low_cnt != LW'(GAP_CLKS)) low_cnt <= low_cnt + 1'b1;
            if (!mii_tx_en)                    hi_cnt  <= '0;
            else if (hi_cnt != 16'hFFFF)       hi_cnt  <= hi_cnt + 1'b1;
        end
    end

    // R1: the first nibble after enable rises is the preamble low nibble
    a_r1_first_nibble: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mii_tx_en) |-> (mii_txd == 4'h5));

    // R5: one unbroken enable run per frame, whole bytes, at least minimum length
    a_r5_unbroken_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mii_tx_en) |-> (hi_cnt >= 16'(MIN_HI) && !hi_cnt[0]));

    // R6: the idle gap is honoured before each new frame
    a_r6_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mii_tx_en) |-> (low_cnt >= LW'(GAP_CLKS)));

    // R7: error line low; data quiet when idle
    a_r7_er_low: assert property (@(posedge clk) disable iff (!rst_n)
        mii_tx_er == 1'b0);
    a_r7_idle_txd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !mii_tx_en |-> (mii_txd == 4'h0));

    // R8: bytes are only taken while a frame is on the wire
    a_r8_ready_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> mii_tx_en);
endmodule

bind mii_tx_framer mii_tx_framer_chk #(
    .PRE_BYTES (PRE_BYTES),
    .MIN_FRAME (MIN_FRAME),
    .GAP_CLKS  (GAP_CLKS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .mii_txd   (mii_txd),
    .mii_tx_en (mii_tx_en),
    .mii_tx_er (mii_tx_er)
);

// File: tb/mii_tx_framer_tb_top.sv
module mii_tx_framer_tb_top;
    typedef logic [7:0] bytes_t[$];

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] in_data;
    logic       in_valid;
    logic       in_last;
    logic       in_ready;
    logic [3:0] mii_txd;
    logic       mii_tx_en;
    logic       mii_tx_er;

    always #2 clk = ~clk;

    mii_tx_framer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .in_ready  (in_ready),
        .mii_txd   (mii_txd),
        .mii_tx_en (mii_tx_en),
        .mii_tx_er (mii_tx_er)
    );

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] exp_q[$];
    int         exp_len_q[$];
    int         exp_pay_q[$];
    logic [3:0] nibs[$];
    bit         exact_gap = 0;
    bit         seen_frame = 0;
    bit         prev_en = 0;
    int         gap_cnt = 0;
    bit         mon_on = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Bench CRC: MSB-first shift register with the normal polynomial, bit-reversed at the end.
    function automatic logic [31:0] ref_fcs(input bytes_t b);
        logic [31:0] c = 32'hFFFFFFFF;
        logic [31:0] r;
        logic        fb;
        foreach (b[k]) begin
            for (int i = 0; i < 8; i++) begin
                fb = c[31] ^ b[k][i];
                c  = {c[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
            end
        end
        for (int i = 0; i < 32; i++) r[i] = c[31 - i];
        return ~r;
    endfunction

    task automatic build_expected(input bytes_t p);
        bytes_t body;
        logic [31:0] f;
        body = p;
        while (body.size() < 60) body.push_back(8'h00);
        f = ref_fcs(body);
        for (int i = 0; i < 7; i++) exp_q.push_back(8'h55);
        exp_q.push_back(8'hD5);
        foreach (body[i]) exp_q.push_back(body[i]);
        for (int i = 0; i < 4; i++) exp_q.push_back(f[8*i +: 8]);
        exp_len_q.push_back(8 + body.size() + 4);
        exp_pay_q.push_back(p.size());
    endtask

    task automatic send(input bytes_t p, input bit use_last);
        int idx = 0;
        int n = p.size();
        build_expected(p);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = p[0];
        in_last  = use_last && (n == 1);
        while (idx < n) begin
            @(negedge clk);
            if (in_ready) begin
                @(posedge clk);
                #1;
                idx++;
                if (idx < n) begin
                    in_data = p[idx];
                    in_last = use_last && (idx == n - 1);
                end else begin
                    in_valid = 1'b0;
                    in_last  = 1'b0;
                end
            end
        end
    endtask

    function automatic bytes_t rand_payload(input int n);
        bytes_t p;
        for (int i = 0; i < n; i++) p.push_back(8'($urandom_range(0, 255)));
        return p;
    endfunction

    task automatic finish_frame();
        int L, plen, bad_i;
        logic [7:0] got, exp, bad_got, bad_exp;
        string region;
        if (exp_len_q.size() == 0) begin
            check(0, "R5", "unexpected frame nibbles", nibs.size(), 0);
            nibs.delete();
            return;
        end
        L    = exp_len_q.pop_front();
        plen = exp_pay_q.pop_front();
        check(nibs.size() == 2 * L, "R5", "unbroken frame nibble count", nibs.size(), 2 * L);
        bad_i = -1;
        bad_got = 8'h00;
        bad_exp = 8'h00;
        for (int i = 0; i < L; i++) begin
            exp = exp_q.pop_front();
            got = (2 * i + 1 < nibs.size()) ? {nibs[2*i+1], nibs[2*i]} : 8'hXX;
            if (bad_i < 0 && got !== exp) begin
                bad_i = i; bad_got = got; bad_exp = exp;
            end
        end
        if (bad_i < 0)                 region = "R1 R2 R3 R4";
        else if (bad_i < 8)            region = "R1";
        else if (bad_i < 8 + plen)     region = "R2";
        else if (bad_i < L - 4)        region = "R3";
        else                           region = "R4";
        check(bad_i < 0, region, $sformatf("frame byte %0d", bad_i), bad_got, bad_exp);
        nibs.delete();
    endtask

    // Monitor away from the active edge.
    always @(negedge clk) begin
        if (mon_on) begin
            if (mii_tx_er !== 1'b0) check(0, "R7", "tx_er high", mii_tx_er, 0);
            if (mii_tx_en) begin
                if (!prev_en) begin
                    if (seen_frame) begin
                        check(gap_cnt >= 24, "R6", "gap clocks", gap_cnt, 24);
                        if (exact_gap) begin
                            check(gap_cnt == 24, "R6", "back-to-back gap", gap_cnt, 24);
                            exact_gap = 0;
                        end
                    end
                    seen_frame = 1;
                end
                gap_cnt = 0;
                nibs.push_back(mii_txd);
            end else begin
                if (mii_txd !== 4'h0) check(0, "R7", "txd while idle", mii_txd, 0);
                if (in_ready)         check(0, "R8", "ready while idle", in_ready, 0);
                if (prev_en) finish_frame();
                gap_cnt++;
            end
            prev_en = mii_tx_en;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        bytes_t p;
        void'($urandom(32'd7717));
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_last  = 1'b0;
        in_data  = 8'h00;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(mii_tx_en == 1'b0, "R10", "reset tx_en", mii_tx_en, 0);
        check(mii_txd == 4'h0,   "R10", "reset txd", mii_txd, 0);
        check(in_ready == 1'b0,  "R10", "reset ready", in_ready, 0);
        mon_on = 1;

        // R3 boundaries: header only, just under, at, just over the minimum
        send(rand_payload(14), 1);
        repeat (40) @(negedge clk);
        send(rand_payload(59), 1);
        repeat (30) @(negedge clk);
        send(rand_payload(60), 1);
        repeat (30) @(negedge clk);
        send(rand_payload(61), 1);
        repeat (30) @(negedge clk);
        // One-byte frame: delimiter slot takes and closes the stream
        send(rand_payload(1), 1);
        repeat (30) @(negedge clk);

        // R6: back-to-back frames, next byte waiting through the gap
        send(rand_payload(64), 1);
        exact_gap = 1;
        send(rand_payload(20), 1);
        repeat (30) @(negedge clk);
        send(rand_payload(75), 1);
        exact_gap = 1;
        send(rand_payload(90), 1);
        repeat (30) @(negedge clk);

        // R9: stream stops without last; frame closes with padding and FCS
        send(rand_payload(30), 0);
        repeat (200) @(negedge clk);
        send(rand_payload(70), 0);
        repeat (200) @(negedge clk);

        // Random lengths and idle spacing (R2, R4)
        for (int k = 0; k < 12; k++) begin
            p = rand_payload($urandom_range(14, 120));
            send(p, 1);
            repeat ($urandom_range(0, 40)) @(negedge clk);
        end

        while (exp_len_q.size() != 0) @(negedge clk);
        repeat (40) @(negedge clk);
        check(nibs.size() == 0, "R5", "trailing nibbles", nibs.size(), 0);
        finish_run();
    end
endmodule